// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block launches a single memory-card command on behalf of a host register interface and captures the answer. The host loads a 6-bit command index and a 32-bit argument, the argument written as two 16-bit halves. It then writes a control word that selects the expected response type. The command starts either when that control word is written while the card clock is enabled, or later when the clock is started with a command still pending.

The command goes out on a card-side request port with a valid/ready handshake. The answer comes back as up to 16 bytes tagged with a byte count. The block checks the count against the response type. It then packs the bytes pairwise into a nine-entry queue of 16-bit words, which the host drains in order through one read port, and it records completion or timeout in a status word. When the control word asks for a data phase, a successful response loads a remaining-byte count equal to blocks times block length. That count is handed to a data engine outside this block.

Host reads are registered: `host_rdata` carries the value selected by a read in the cycle after `host_rd`. Register selects: 0 control word, 1 clock control, 2 command index, 3 argument high, 4 argument low, 5 status, 6 response queue, 7 interrupt request, 8 block length, 9 block count.

Top module: `card_cmd_seq`

## Requirements
- R1: After reset the status word reads 0, the command register reads 0x40, the interrupt word reads 0, and `req_valid` and `xfer_active` are low.
- R2: Writing select 2 stores bits [5:0] of the write data. Reading it returns that index OR 0x40. Selects 3 and 4 read back the upper and lower argument halves separately. A launched request presents the index on `req_cmd` and {high, low} on `req_arg`.
- R3: A control-word write with bit 10 (stop-transfer) clear launches a request while the clock is enabled and no exchange is in flight. With the clock off it only leaves a command pending, and a later clock write with bit 1 set launches it. A control-word write with bit 10 set launches nothing, either at once or on a later clock start.
- R4: `req_valid` rises in the cycle after the launching write. It stays high with stable `req_cmd` and `req_arg` until `req_ready` is seen. `rsp_ready` is high only after the request was accepted and until a response is taken, and never together with `req_valid`.
- R5: Control bits [1:0] select the response type: 0 needs no bytes, 1 and 3 need at least 4 bytes, and 2 needs at least 16 bytes. A shorter `rsp_len`, including 0, sets status bit 1, leaves `xfer_active` low, and leaves every queue entry reading 0.
- R6: On a passing response, queue entry k holds byte 2k in bits [7:0] and byte 2k+1 in bits [15:8]. Byte i is `rsp_data[8i+7:8i]`. Bytes at or beyond `rsp_len`, and entries with no bytes, read 0.
- R7: Each read of select 6 returns the next of the nine entries, starting at entry 0 after a passing response. Once all nine have been read, further reads return 0.
- R8: A passing response sets status bit 13. If control bit 2 (data enable) is set and the clock is still enabled, `xfer_active` rises and `xfer_bytes` equals block count × block length. Otherwise `xfer_active` stays low.
- R9: Status bit 8 mirrors the clock enable. A control-word write clears `xfer_active`, and when its bit 10 is clear it also clears status bits 1 and 13. A clock write with bit 0 set clears bit 8 and `xfer_active`.
- R10: Every completed exchange sets interrupt bit 2, which reads back at select 7 and is cleared by writing 1 to bit 2 there. A launch clears the pending command, so a second clock start does not issue it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 4 | Register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid the cycle after `host_rd` |
| req_valid | output | 1 | Command request valid |
| req_ready | input | 1 | Card side accepts the request |
| req_cmd | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Block waits for a response |
| rsp_len | input | 5 | Response byte count |
| rsp_data | input | 128 | Response bytes, byte i at bits [8i+7:8i] |
| xfer_active | output | 1 | Data phase armed |
| xfer_bytes | output | 28 | Remaining byte count for the data phase |

## Verification
The assertions assume the card side obeys the handshake. It offers `rsp_valid` only while `rsp_ready` is high, and it never answers a request that was not accepted. They also assume the host does not write the control word or the clock control while an exchange is in flight, and does not set both clock bits in one write. The bench drives the card side from a single responder task that waits for `req_valid`, optionally stalls `req_ready`, and then answers once. Every host write is issued only after the previous exchange has completed, so the stimulus never leaves these assumptions.

// File: rtl/card_cmd_seq.sv
module card_cmd_seq #(
  parameter int BLEN_W    = 12,
  parameter int BCNT_W    = 16,
  parameter int RQ_DEPTH  = 9,
  parameter int RSP_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_wr,
  input  logic                         host_rd,
  input  logic [3:0]                   host_addr,
  input  logic [15:0]                  host_wdata,
  output logic [15:0]                  host_rdata,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [5:0]                   req_cmd,
  output logic [31:0]                  req_arg,
  input  logic                         rsp_valid,
  output logic                         rsp_ready,
  input  logic [$clog2(RSP_BYTES+1)-1:0] rsp_len,
  input  logic [RSP_BYTES*8-1:0]       rsp_data,
  output logic                         xfer_active,
  output logic [BLEN_W+BCNT_W-1:0]     xfer_bytes
);
  localparam int LEN_W = $clog2(RSP_BYTES+1);
  localparam int IDX_W = $clog2(RQ_DEPTH+1);
  localparam int XB_W  = BLEN_W + BCNT_W;

  localparam logic [3:0] A_CTRL = 4'd0, A_CLK = 4'd1, A_CMD = 4'd2, A_ARGH = 4'd3,
                         A_ARGL = 4'd4, A_STAT = 4'd5, A_RESP = 4'd6, A_IRQ = 4'd7,
                         A_BLEN = 4'd8, A_BCNT = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t                st;
  logic [13:0]        ctrl;
  logic [5:0]         cmd;
  logic [15:0]        arg_hi, arg_lo;
  logic [BLEN_W-1:0]  blen;
  logic [BCNT_W-1:0]  bcnt;
  logic               clk_en, pending, active, f_tout, f_done, irq_end;
  logic [15:0]        rq [RQ_DEPTH];
  logic [IDX_W-1:0]   ridx;
  logic [XB_W-1:0]    xb;

  wire wr_ctrl  = host_wr && host_addr == A_CTRL;
  wire wr_clk   = host_wr && host_addr == A_CLK;
  wire wr_irq   = host_wr && host_addr == A_IRQ;
  wire rd_resp  = host_rd && host_addr == A_RESP;
  wire idle     = st == S_IDLE;
  wire busy     = !idle;
  wire launch_w = wr_ctrl && !host_wdata[10] && clk_en && idle;
  wire launch_c = wr_clk && host_wdata[1] && pending && !ctrl[10] && idle;
  wire launch   = launch_w || launch_c;
  wire rsp_hs   = rsp_valid && rsp_ready;

  wire [LEN_W-1:0] need = (ctrl[1:0] == 2'd0) ? '0 :
                          (ctrl[1:0] == 2'd2) ? LEN_W'(RSP_BYTES) : LEN_W'(4);
  wire rsp_ok = rsp_len >= need;

  wire [15:0] status = {2'b00, f_done, 4'b0000, clk_en, 6'b000000, f_tout, 1'b0};

  function automatic logic [7:0] byte_at(input int i);
    if (i < int'(rsp_len) && i < RSP_BYTES) return rsp_data[8*(i % RSP_BYTES) +: 8];
    return 8'h00;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ctrl    <= '0;
      cmd     <= '0;
      arg_hi  <= '0;
      arg_lo  <= '0;
      blen    <= '0;
      bcnt    <= '0;
      clk_en  <= 1'b0;
      pending <= 1'b0;
      active  <= 1'b0;
      f_tout  <= 1'b0;
      f_done  <= 1'b0;
      irq_end <= 1'b0;
      ridx    <= '0;
      xb      <= '0;
      for (int k = 0; k < RQ_DEPTH; k++) rq[k] <= '0;
    end else begin
      case (st)
        S_IDLE:  if (launch) st <= S_REQ;
        S_REQ:   if (req_ready) st <= S_WAIT;
        default: if (rsp_valid) st <= S_IDLE;
      endcase

      if (wr_ctrl) ctrl <= host_wdata[13:0];
      if (host_wr && host_addr == A_CMD)  cmd    <= host_wdata[5:0];
      if (host_wr && host_addr == A_ARGH) arg_hi <= host_wdata;
      if (host_wr && host_addr == A_ARGL) arg_lo <= host_wdata;
      if (host_wr && host_addr == A_BLEN) blen   <= host_wdata[BLEN_W-1:0];
      if (host_wr && host_addr == A_BCNT) bcnt   <= host_wdata[BCNT_W-1:0];

      if (launch)       pending <= 1'b0;
      else if (wr_ctrl) pending <= 1'b1;

      if (wr_clk) begin
        if (host_wdata[0])      clk_en <= 1'b0;
        else if (host_wdata[1]) clk_en <= 1'b1;
      end

      if ((wr_ctrl && !host_wdata[10]) || launch_c) begin
        f_tout <= 1'b0;
        f_done <= 1'b0;
      end

      if (rsp_hs) begin
        active  <= rsp_ok && ctrl[2] && clk_en;
        irq_end <= 1'b1;
        if (rsp_ok) begin
          f_done <= 1'b1;
          ridx   <= '0;
          if (ctrl[2]) xb <= XB_W'(bcnt) * XB_W'(blen);
        end else begin
          f_tout <= 1'b1;
        end
        for (int k = 0; k < RQ_DEPTH; k++)
          rq[k] <= rsp_ok ? {byte_at(2*k+1), byte_at(2*k)} : 16'h0000;
      end else if (rd_resp && ridx < IDX_W'(RQ_DEPTH)) begin
        ridx <= ridx + 1'b1;
      end

      if (wr_irq && host_wdata[2] && !rsp_hs) irq_end <= 1'b0;
      if (wr_ctrl || (wr_clk && host_wdata[0])) active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_rd) begin
      case (host_addr)
        A_CTRL:  host_rdata <= {2'b00, ctrl};
        A_CMD:   host_rdata <= {10'd0, cmd} | 16'h0040;
        A_ARGH:  host_rdata <= arg_hi;
        A_ARGL:  host_rdata <= arg_lo;
        A_STAT:  host_rdata <= status;
        A_RESP:  host_rdata <= (ridx < IDX_W'(RQ_DEPTH)) ? rq[ridx] : 16'h0000;
        A_IRQ:   host_rdata <= {13'd0, irq_end, 2'b00};
        A_BLEN:  host_rdata <= 16'(blen);
        A_BCNT:  host_rdata <= 16'(bcnt);
        default: host_rdata <= 16'h0000;
      endcase
    end
  end

  assign req_valid   = st == S_REQ;
  assign rsp_ready   = st == S_WAIT;
  assign req_cmd     = cmd;
  assign req_arg     = {arg_hi, arg_lo};
  assign xfer_active = active;
  assign xfer_bytes  = xb;
endmodule

// File: rtl/card_cmd_seq_chk.sv
module card_cmd_seq_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic [3:0]       host_addr,
  input logic [15:0]      host_wdata,
  input logic             req_valid,
  input logic             req_ready,
  input logic [5:0]       req_cmd,
  input logic [31:0]      req_arg,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [LEN_W-1:0] rsp_len,
  input logic             xfer_active,
  input logic             clk_en,
  input logic             busy,
  input logic [1:0]       rsp_type,
  input logic             st_tout,
  input logic             st_done,
  input logic             irq_end
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_cmd) && $stable(req_arg));

  // R4
  hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 4'd0 && !host_wdata[10] && clk_en && !busy |=> req_valid);

  // R5
  short_tout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_type != 2'd0 && rsp_len < LEN_W'(4) |=> st_tout && !xfer_active);

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> st_tout != st_done);

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> irq_end);
endmodule

bind card_cmd_seq card_cmd_seq_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .req_valid(req_valid), .req_ready(req_ready),
  .req_cmd(req_cmd), .req_arg(req_arg), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_len(rsp_len), .xfer_active(xfer_active),
  .clk_en(clk_en), .busy(busy), .rsp_type(ctrl[1:0]), .st_tout(f_tout),
  .st_done(f_done), .irq_end(irq_end)
);

// File: tb/card_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module card_cmd_seq_tb_top;
  logic         clk = 0, rst_n = 0;
  logic         host_wr = 0, host_rd = 0;
  logic [3:0]   host_addr = 0;
  logic [15:0]  host_wdata = 0, host_rdata;
  logic         req_valid, req_ready = 0, rsp_valid = 0, rsp_ready, xfer_active;
  logic [5:0]   req_cmd;
  logic [31:0]  req_arg;
  logic [4:0]   rsp_len = 0;
  logic [127:0] rsp_data = 0;
  logic [27:0]  xfer_bytes;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  card_cmd_seq dut_i (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  function automatic logic [127:0] mkdata(input logic [7:0] base);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = base + 8'(i);
    return v;
  endfunction

  function automatic logic [15:0] exp_entry(input int k, input int len, input logic [7:0] base);
    logic [7:0] lo, hi;
    lo = (2*k < len && 2*k < 16) ? base + 8'(2*k) : 8'h00;
    hi = (2*k+1 < len && 2*k+1 < 16) ? base + 8'(2*k+1) : 8'h00;
    return {hi, lo};
  endfunction

  task automatic serve(input logic [5:0] ecmd, input logic [31:0] earg,
                       input int len, input logic [7:0] base, input int stall);
    int n;
    n = 0;
    while (!req_valid && n < 20) begin @(negedge clk); n++; end
    chk(req_valid, 1, "R3 request launched");
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(req_valid, 1, "R4 valid held while stalled");
    end
    chk(req_cmd, ecmd, "R2 req_cmd");
    chk(req_arg, earg, "R2 req_arg");
    chk(rsp_ready, 0, "R4 no rsp_ready before accept");
    req_ready = 1;
    @(negedge clk); req_ready = 0;
    chk(rsp_ready, 1, "R4 rsp_ready after accept");
    rsp_valid = 1; rsp_len = 5'(len); rsp_data = mkdata(base);
    @(negedge clk); rsp_valid = 0;
  endtask

  task automatic check_queue(input int len, input logic [7:0] base, input string tag);
    logic [15:0] d;
    for (int k = 0; k < 9; k++) begin
      rd(4'd6, d);
      chk(d, exp_entry(k, len, base), tag);
    end
    rd(4'd6, d);
    chk(d, 0, "R7 read past nine entries");
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(4'd5, d); chk(d, 0, "R1 status");
    rd(4'd2, d); chk(d, 16'h40, "R1 cmd readback");
    rd(4'd7, d); chk(d, 0, "R1 irq");
    chk(req_valid, 0, "R1 req_valid");
    chk(xfer_active, 0, "R1 xfer_active");
  endtask

  task automatic t_regs;
    logic [15:0] d;
    wr(4'd2, 16'h00FF); rd(4'd2, d); chk(d, 16'h7F, "R2 index OR 0x40");
    wr(4'd2, 16'h0011); rd(4'd2, d); chk(d, 16'h51, "R2 index OR 0x40");
    wr(4'd3, 16'h1234); wr(4'd4, 16'hABCD);
    rd(4'd3, d); chk(d, 16'h1234, "R2 arg high");
    rd(4'd4, d); chk(d, 16'hABCD, "R2 arg low");
  endtask

  task automatic t_pending_launch;
    logic [15:0] d;
    wr(4'd0, 16'h0001);
    repeat (3) @(negedge clk);
    chk(req_valid, 0, "R3 no launch while clock off");
    wr(4'd1, 16'h0002);
    serve(6'h11, 32'h1234ABCD, 5, 8'hA0, 2);
    rd(4'd5, d); chk(d, 16'h2100, "R8 done and clock bits");
    chk(xfer_active, 0, "R8 idle without data enable");
    rd(4'd7, d); chk(d, 16'h0004, "R10 end-of-command irq");
    check_queue(5, 8'hA0, "R6 odd-length packing");
    wr(4'd7, 16'h0004); rd(4'd7, d); chk(d, 0, "R10 irq cleared");
    wr(4'd1, 16'h0002);
    repeat (3) @(negedge clk);
    chk(req_valid, 0, "R10 pending cleared by launch");
  endtask

  task automatic t_long;
    logic [15:0] d;
    wr(4'd2, 16'h0002);
    wr(4'd0, 16'h0002);
    serve(6'h02, 32'h1234ABCD, 16, 8'h10, 0);
    rd(4'd5, d); chk(d, 16'h2100, "R5 long response passes");
    check_queue(16, 8'h10, "R7 long response in order");
  endtask

  task automatic t_timeouts;
    logic [15:0] d;
    wr(4'd0, 16'h0002);
    serve(6'h02, 32'h1234ABCD, 15, 8'h30, 0);
    rd(4'd5, d); chk(d, 16'h0102, "R5 15 bytes for long type");
    rd(4'd6, d); chk(d, 0, "R5 queue zero after timeout");
    wr(4'd0, 16'h0001);
    serve(6'h02, 32'h1234ABCD, 0, 8'h30, 0);
    rd(4'd5, d); chk(d, 16'h0102, "R5 zero length short type");
    wr(4'd0, 16'h0003);
    serve(6'h02, 32'h1234ABCD, 3, 8'h30, 0);
    rd(4'd5, d); chk(d, 16'h0102, "R5 3 bytes type 3");
    wr(4'd0, 16'h0003);
    serve(6'h02, 32'h1234ABCD, 4, 8'h40, 1);
    rd(4'd5, d); chk(d, 16'h2100, "R5 4 bytes type 3 passes");
    rd(4'd6, d); chk(d, 16'h4140, "R6 first entry");
    wr(4'd0, 16'h0000);
    serve(6'h02, 32'h1234ABCD, 0, 8'h40, 0);
    rd(4'd5, d); chk(d, 16'h2100, "R5 type 0 needs nothing");
  endtask

  task automatic t_data;
    logic [15:0] d;
    wr(4'd8, 16'd512); wr(4'd9, 16'd3);
    wr(4'd0, 16'h0005);
    serve(6'h02, 32'h1234ABCD, 4, 8'h50, 0);
    chk(xfer_active, 1, "R8 data phase armed");
    chk(xfer_bytes, 28'd1536, "R8 blocks times length");
    wr(4'd0, 16'h0405);
    repeat (2) @(negedge clk);
    chk(req_valid, 0, "R3 stop-transfer write does not launch");
    chk(xfer_active, 0, "R9 control write clears active");
    rd(4'd5, d); chk(d, 16'h2100, "R9 stop-transfer keeps status");
    wr(4'd1, 16'h0002);
    repeat (2) @(negedge clk);
    chk(req_valid, 0, "R3 clock start with stop-transfer");
    wr(4'd0, 16'h0005);
    serve(6'h02, 32'h1234ABCD, 4, 8'h50, 0);
    chk(xfer_active, 1, "R8 armed again");
    wr(4'd1, 16'h0001);
    chk(xfer_active, 0, "R9 stop clock aborts");
    rd(4'd5, d); chk(d, 16'h2000, "R9 clock bit cleared");
    wr(4'd0, 16'h0001);
    rd(4'd5, d); chk(d, 16'h0000, "R9 control write clears status");
    wr(4'd1, 16'h0002);
    serve(6'h02, 32'h1234ABCD, 4, 8'h60, 0);
    rd(4'd5, d); chk(d, 16'h2100, "R3 launch on clock start");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regs;
    t_pending_launch;
    t_long;
    t_timeouts;
    t_data;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule